// File: doc/BRIEF.md
# Block address translation matcher

This block maps a 32-bit effective address onto a real address through four fixed-size-or-larger memory blocks. Each block is described by a pair of 32-bit words: an upper word that gives the effective block base, the block length and two validity bits (one for supervisor state, one for user state), and a lower word that gives the real block base and a two-bit protection code. Software loads the pairs through a single-cycle register-write port. One instance serves the instruction side and another serves the data side.

For every request strobe the block reports, one cycle later, whether a block matched, whether the access type is forbidden by that block's protection code, and the translated real address. Only entries whose validity bit for the current privilege state is set take part, and the lowest-numbered matching entry wins. When relocation is switched off for the map, the effective address passes straight through with no check.

Top module: `blk_xlate`

## Requirements
- R1: `rsp_vld` is high in exactly the cycle after `req_vld` was sampled high; whenever `rsp_vld` is low, `rsp_hit`, `rsp_fault` and `rsp_ra` are all zero.
- R2: A write with `cfg_we` high stores `cfg_wdata` into pair `cfg_addr[2:1]`, upper word when `cfg_addr[0]`=0 and lower word when `cfg_addr[0]`=1; a request sampled on the same edge as the write still uses the old contents, and later requests use the new ones.
- R3: Upper word bit 1 is the supervisor-valid bit and bit 0 the user-valid bit; an entry takes part only if the bit for the current state (`priv_user`=0 supervisor, 1 user) is set. The privilege input is registered, so a request sampled on the edge where `priv_user` changes still uses the previous state.
- R4: The length mask is bits [16:0] all ones, bits [27:17] equal to upper word bits [12:2], bits [31:28] zero; an entry matches when (EA AND NOT mask) equals upper word bits [31:17] followed by 17 zero bits, so base bits set inside the length area prevent any match.
- R5: On a permitted hit, `rsp_ra` = (EA AND mask) OR (lower word bits [31:17] followed by 17 zeros); the low 17 EA bits always pass through.
- R6: `req_kind` encodes 00 read, 01 write, 10 fetch, 11 fetch. The protection code is lower word bits [1:0]: 00 forbids everything, 01 and 11 forbid writes only, 10 allows all. A forbidden hit gives `rsp_hit`=1, `rsp_fault`=1 and `rsp_ra`=0.
- R7: When several live entries match, the lowest-numbered one decides address and protection.
- R8: With relocation on and no live entry matching, `rsp_hit`=0, `rsp_fault`=0, `rsp_ra`=0.
- R9: With `reloc_en`=0 at the request, `rsp_ra` equals the request address and `rsp_hit`=`rsp_fault`=0, whatever the entries hold.
- R10: Synchronous active-low reset clears all eight words (no entry live) and all response outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Pair index in [2:1], lower/upper select in [0] |
| cfg_wdata | input | 32 | Register write data |
| priv_user | input | 1 | 1 in user state, 0 in supervisor state |
| reloc_en | input | 1 | Relocation enable for this map |
| req_vld | input | 1 | Lookup request strobe |
| req_ea | input | 32 | Effective address |
| req_kind | input | 2 | Access type |
| rsp_vld | output | 1 | Response valid |
| rsp_hit | output | 1 | A live entry matched |
| rsp_fault | output | 1 | Matched entry forbids this access type |
| rsp_ra | output | 32 | Real address |

## Verification
On every cycle the assertions check the one-cycle response timing, the zeroed outputs between responses, that a fault always comes with a hit and a zero address, that the offset below the minimum block size passes through on a permitted hit, the zero address on a miss, and the straight-through path when relocation is off. Which entry wins, how the length field widens a block, which protection code blocks which access type, and how privilege state and register writes change the live set can only be shown by the bench's scenarios, which compare each response with addresses worked out by hand from the programmed words.

// File: rtl/blkx_pkg.sv
// Shared types for the block address translation matcher.
// Assumes a two-bit access type code driven by the requester.
package blkx_pkg;

    // Access type seen on the request port; code 11 behaves as a fetch.
    typedef enum logic [1:0] {
        ACC_LOAD      = 2'b00,
        ACC_STORE     = 2'b01,
        ACC_FETCH     = 2'b10,
        ACC_FETCH_ALT = 2'b11
    } acc_kind_e;

    // Width of the protection code held in each lower word.
    localparam int PROT_W = 2;

endpackage

// File: rtl/blkx_cfg.sv
// Register file for the translation pairs.
// Holds N_ENT upper/lower word pairs written one word per cycle.
// Assumes the address selects the pair in its upper bits and the word in bit 0.
module blkx_cfg #(
    parameter int N_ENT = 4,
    parameter int DW    = 32,
    localparam int SEL_W = $clog2(N_ENT),
    localparam int CA_W  = SEL_W + 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [CA_W-1:0]            addr,
    input  logic [DW-1:0]              wdata,
    output logic [N_ENT-1:0][DW-1:0]   upper_o,
    output logic [N_ENT-1:0][DW-1:0]   lower_o
);

    logic [N_ENT-1:0][DW-1:0] upper_q;
    logic [N_ENT-1:0][DW-1:0] lower_q;

    // Store one word per write strobe; reset clears every pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upper_q <= '0;
            lower_q <= '0;
        end else if (we) begin
            if (addr[0]) lower_q[addr[CA_W-1:1]] <= wdata;
            else         upper_q[addr[CA_W-1:1]] <= wdata;
        end
    end

    assign upper_o = upper_q;
    assign lower_o = lower_q;

endmodule

// File: rtl/blkx_entry.sv
// One translation entry: liveness for the privilege state, length mask,
// address match and real-address formation.
// Assumes upper = {base, spare, length, sv, uv} and lower = {real base, spare, prot}.
module blkx_entry #(
    parameter int DW     = 32,
    parameter int BL_W   = 11,
    parameter int MIN_SH = 17,
    localparam int BL_LSB = 2,
    localparam int BASE_W = DW - MIN_SH
) (
    input  logic                       user_mode,
    input  logic [DW-1:0]              upper,
    input  logic [DW-1:0]              lower,
    input  logic [DW-1:0]              ea,
    output logic                       match,
    output logic [DW-1:0]              ra,
    output logic [blkx_pkg::PROT_W-1:0] prot
);

    logic          live;
    logic [DW-1:0] len_mask;
    logic [DW-1:0] base_ea;
    logic [DW-1:0] base_ra;
    logic          unused_bits;

    // Pick the validity bit belonging to the current privilege state.
    assign live = user_mode ? upper[0] : upper[1];

    // Build the block length mask: fixed minimum block plus the length field.
    always_comb begin
        len_mask = '0;
        len_mask[MIN_SH-1:0] = '1;
        len_mask[MIN_SH+BL_W-1:MIN_SH] = upper[BL_LSB+BL_W-1:BL_LSB];
    end

    assign base_ea = {upper[DW-1:MIN_SH], {MIN_SH{1'b0}}};
    assign base_ra = {lower[DW-1:MIN_SH], {MIN_SH{1'b0}}};

    // Compare the block part of the address and splice the real base in.
    assign match = live && ((ea & ~len_mask) == base_ea);
    assign ra    = (ea & len_mask) | base_ra;
    assign prot  = lower[blkx_pkg::PROT_W-1:0];

    assign unused_bits = ^{upper[MIN_SH-1:BL_LSB+BL_W], lower[MIN_SH-1:blkx_pkg::PROT_W]};

endmodule

// File: rtl/blkx_perm.sv
// Protection decode for a matched entry with the key fixed at one.
// Assumes code 00 blocks all, 10 allows all, 01/11 block stores only.
module blkx_perm
    import blkx_pkg::*;
(
    input  logic [PROT_W-1:0] prot,
    input  acc_kind_e         kind,
    output logic              allow
);

    // Map protection code and access type onto a permit bit.
    always_comb begin
        unique case (prot)
            2'b00:   allow = 1'b0;
            2'b10:   allow = 1'b1;
            default: allow = (kind != ACC_STORE);
        endcase
    end

endmodule

// File: rtl/blk_xlate.sv
// Block address translation matcher, top level.
// Looks up a request against the live entries and registers hit, fault and
// real address one cycle after the request strobe.
// Assumes entries of equal priority are resolved by lowest index.
module blk_xlate #(
    parameter int N_ENT  = 4,
    parameter int DW     = 32,
    parameter int BL_W   = 11,
    parameter int MIN_SH = 17,
    localparam int CA_W  = $clog2(N_ENT) + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [CA_W-1:0] cfg_addr,
    input  logic [DW-1:0]   cfg_wdata,
    input  logic            priv_user,
    input  logic            reloc_en,
    input  logic            req_vld,
    input  logic [DW-1:0]   req_ea,
    input  logic [1:0]      req_kind,
    output logic            rsp_vld,
    output logic            rsp_hit,
    output logic            rsp_fault,
    output logic [DW-1:0]   rsp_ra
);
    import blkx_pkg::*;

    logic [N_ENT-1:0][DW-1:0]     upper_w;
    logic [N_ENT-1:0][DW-1:0]     lower_w;
    logic [N_ENT-1:0]             ent_match;
    logic [N_ENT-1:0][DW-1:0]     ent_ra;
    logic [N_ENT-1:0][PROT_W-1:0] ent_prot;
    logic                         priv_q;
    logic                         sel_hit;
    logic [DW-1:0]                sel_ra;
    logic [PROT_W-1:0]            sel_prot;
    logic                         sel_allow;

    blkx_cfg #(.N_ENT(N_ENT), .DW(DW)) cfg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .upper_o (upper_w),
        .lower_o (lower_w)
    );

    // Register the privilege state so the live set changes between lookups.
    always_ff @(posedge clk) begin
        if (!rst_n) priv_q <= 1'b0;
        else        priv_q <= priv_user;
    end

    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        blkx_entry #(.DW(DW), .BL_W(BL_W), .MIN_SH(MIN_SH)) ent_i (
            .user_mode (priv_q),
            .upper     (upper_w[g]),
            .lower     (lower_w[g]),
            .ea        (req_ea),
            .match     (ent_match[g]),
            .ra        (ent_ra[g]),
            .prot      (ent_prot[g])
        );
    end

    // Select the lowest-numbered matching entry.
    always_comb begin
        sel_hit  = 1'b0;
        sel_ra   = '0;
        sel_prot = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (ent_match[i]) begin
                sel_hit  = 1'b1;
                sel_ra   = ent_ra[i];
                sel_prot = ent_prot[i];
            end
        end
    end

    blkx_perm perm_i (
        .prot  (sel_prot),
        .kind  (acc_kind_e'(req_kind)),
        .allow (sel_allow)
    );

    // Register the response; outputs read zero outside a response cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_vld   <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_ra    <= '0;
        end else begin
            rsp_vld <= req_vld;
            if (req_vld && !reloc_en) begin
                rsp_hit   <= 1'b0;
                rsp_fault <= 1'b0;
                rsp_ra    <= req_ea;
            end else if (req_vld) begin
                rsp_hit   <= sel_hit;
                rsp_fault <= sel_hit && !sel_allow;
                rsp_ra    <= (sel_hit && sel_allow) ? sel_ra : '0;
            end else begin
                rsp_hit   <= 1'b0;
                rsp_fault <= 1'b0;
                rsp_ra    <= '0;
            end
        end
    end

endmodule

// File: rtl/blkx_chk.sv
// Cycle-by-cycle checks on the matcher's ports, attached by bind.
// Assumes the default minimum block offset width.
module blkx_chk #(
    parameter int DW     = 32,
    parameter int MIN_SH = 17
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reloc_en,
    input logic          req_vld,
    input logic [DW-1:0] req_ea,
    input logic          rsp_vld,
    input logic          rsp_hit,
    input logic          rsp_fault,
    input logic [DW-1:0] rsp_ra
);

    logic armed;

    // Mark the cycles that have a post-reset cycle behind them.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    p_resp_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (rsp_vld == $past(req_vld)));

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_vld |-> (!rsp_hit && !rsp_fault && rsp_ra == '0));

    p_fault_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_hit && rsp_ra == '0));

    p_offset_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && rsp_hit && !rsp_fault) |-> (rsp_ra[MIN_SH-1:0] == $past(req_ea[MIN_SH-1:0])));

    p_miss_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && rsp_vld && !rsp_hit && $past(reloc_en)) |-> (rsp_ra == '0));

    p_bypass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(req_vld && !reloc_en)) |->
            (rsp_ra == $past(req_ea) && !rsp_hit && !rsp_fault));

endmodule

bind blk_xlate blkx_chk #(.DW(DW), .MIN_SH(MIN_SH)) chk_i (.*);

// File: tb/blk_xlate_tb_top.sv
`timescale 1ns/1ps
module blk_xlate_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [2:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic        priv_user;
    logic        reloc_en;
    logic        req_vld;
    logic [31:0] req_ea;
    logic [1:0]  req_kind;
    logic        rsp_vld;
    logic        rsp_hit;
    logic        rsp_fault;
    logic [31:0] rsp_ra;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    blk_xlate dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .priv_user(priv_user), .reloc_en(reloc_en),
        .req_vld(req_vld), .req_ea(req_ea), .req_kind(req_kind),
        .rsp_vld(rsp_vld), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault), .rsp_ra(rsp_ra)
    );

    // Vector: {kind, ea, hit, fault, ra}; supervisor state, relocation on.
    localparam logic [67:0] VEC [0:10] = '{
        {2'b00, 32'h2000_1234, 1'b1, 1'b0, 32'h8000_1234},  // R5 entry 0
        {2'b01, 32'h2001_FFFC, 1'b1, 1'b0, 32'h8001_FFFC},  // R7 entry 0 over 2
        {2'b00, 32'h2002_0000, 1'b0, 1'b0, 32'h0000_0000},  // R8 past 128 KB
        {2'b00, 32'h4007_0010, 1'b1, 1'b0, 32'h9007_0010},  // R4 512 KB block
        {2'b01, 32'h4000_0000, 1'b1, 1'b1, 32'h0000_0000},  // R6 code 01 write
        {2'b10, 32'h4001_0000, 1'b1, 1'b0, 32'h9001_0000},  // R6 code 01 fetch
        {2'b00, 32'h4008_0000, 1'b0, 1'b0, 32'h0000_0000},  // R4 past 512 KB
        {2'b01, 32'h6000_0100, 1'b1, 1'b1, 32'h0000_0000},  // R6 code 11 write
        {2'b10, 32'h6000_0100, 1'b1, 1'b0, 32'hB000_0100},  // R6 code 11 fetch
        {2'b11, 32'h6000_0004, 1'b1, 1'b0, 32'hB000_0004},  // R6 kind 11
        {2'b00, 32'h0000_0000, 1'b0, 1'b0, 32'h0000_0000}   // R8 no region
    };

    task automatic check_rsp(input string tag, input logic eh, input logic ef, input logic [31:0] er);
        total++;
        if (rsp_vld !== 1'b1 || rsp_hit !== eh || rsp_fault !== ef || rsp_ra !== er) begin
            bad++;
            $display("FAIL %s: got vld=%b hit=%b fault=%b ra=%h, want vld=1 hit=%b fault=%b ra=%h",
                     tag, rsp_vld, rsp_hit, rsp_fault, rsp_ra, eh, ef, er);
        end
    endtask

    task automatic check_idle(input string tag);
        total++;
        if (rsp_vld !== 1'b0 || rsp_hit !== 1'b0 || rsp_fault !== 1'b0 || rsp_ra !== 32'h0) begin
            bad++;
            $display("FAIL %s: got vld=%b hit=%b fault=%b ra=%h, want all zero",
                     tag, rsp_vld, rsp_hit, rsp_fault, rsp_ra);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic lookup(input logic [1:0] k, input logic [31:0] ea);
        @(negedge clk);
        req_vld = 1'b1; req_kind = k; req_ea = ea;
        @(negedge clk);
        req_vld = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: got no finish, want finish before limit");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        priv_user = 1'b0; reloc_en = 1'b1; req_vld = 1'b0; req_ea = '0; req_kind = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R10 outputs after reset");
        lookup(2'b00, 32'h0000_0000);
        check_rsp("R10 no entry live after reset", 1'b0, 1'b0, 32'h0);
        @(negedge clk);
        check_idle("R1 outputs clear after response");

        // Program pairs: {index, word select}.
        wr(3'd0, 32'h2000_0002); wr(3'd1, 32'h8000_0002);
        wr(3'd2, 32'h4000_000F); wr(3'd3, 32'h9000_0001);
        wr(3'd4, 32'h2000_0003); wr(3'd5, 32'hA000_0000);
        wr(3'd6, 32'h6000_0002); wr(3'd7, 32'hB000_0003);

        for (int i = 0; i < 11; i++) begin
            lookup(VEC[i][67:66], VEC[i][65:34]);
            check_rsp($sformatf("R2/R4/R5/R6/R7/R8 vector %0d", i), VEC[i][33], VEC[i][32], VEC[i][31:0]);
        end

        // User state: entry 0 drops out, entry 2 (code 00) now decides.
        priv_user = 1'b1;
        lookup(2'b00, 32'h2000_0010);
        check_rsp("R3 user state picks entry 2, code 00 faults", 1'b1, 1'b1, 32'h0);
        lookup(2'b10, 32'h6000_0000);
        check_rsp("R3 supervisor-only entry misses in user state", 1'b0, 1'b0, 32'h0);
        lookup(2'b00, 32'h4000_0004);
        check_rsp("R3 user-valid entry hits in user state", 1'b1, 1'b0, 32'h9000_0004);

        // Privilege change on the request edge still uses the old state.
        @(negedge clk);
        priv_user = 1'b0; req_vld = 1'b1; req_kind = 2'b00; req_ea = 32'h6000_0000;
        @(negedge clk);
        req_vld = 1'b0;
        check_rsp("R3 same-edge privilege change uses old state", 1'b0, 1'b0, 32'h0);
        lookup(2'b00, 32'h6000_0000);
        check_rsp("R3 new privilege state applies next", 1'b1, 1'b0, 32'hB000_0000);

        // Relocation off: straight through.
        reloc_en = 1'b0;
        lookup(2'b01, 32'h2000_0010);
        check_rsp("R9 relocation off passes address", 1'b0, 1'b0, 32'h2000_0010);
        reloc_en = 1'b1;

        // Write on the request edge: old contents used, new ones after.
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 3'd6; cfg_wdata = 32'h6002_0006;
        req_vld = 1'b1; req_kind = 2'b00; req_ea = 32'h6000_0000;
        @(negedge clk);
        cfg_we = 1'b0; req_vld = 1'b0;
        check_rsp("R2 same-edge write sees old entry", 1'b1, 1'b0, 32'hB000_0000);
        lookup(2'b00, 32'h6002_0000);
        check_rsp("R4 base bit inside length area blocks match", 1'b0, 1'b0, 32'h0);
        lookup(2'b00, 32'h6000_0000);
        check_rsp("R4 base bit inside length area blocks low half", 1'b0, 1'b0, 32'h0);

        // Widen entry 3 to 256 KB with a clean base.
        wr(3'd6, 32'h6000_0006);
        lookup(2'b10, 32'h6003_1234);
        check_rsp("R4 length bit widens block", 1'b1, 1'b0, 32'hB003_1234);

        @(negedge clk);
        check_idle("R1 outputs clear between requests");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule